// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Sequencer

This block is the device-side read path of a double-data-rate memory. On each rising clock edge it decodes the active-low control pins. When they form a read command and no earlier burst is still in flight, it captures the starting column from the address pins. It then counts the read latency, which is the sum of the posted (additive) latency and the CAS latency, both taken from configuration inputs. After that count it drives a data strobe and a burst of 4 or 8 data beats from an internal column-indexed storage array.

Both-edge data is modelled as two words per clock. The rising-half word carries the even beat and the falling-half word carries the odd beat. The strobe and its enable are likewise given separately for each half-cycle. A one-cycle low strobe preamble comes before the first beat. A half-cycle low postamble follows the last beat, after which the strobe and data are released (enables low). A simple load port fills the storage array before reads are issued.

Top module: `ddr_rd_sequencer`

## Requirements
- R1: A read is recognised only when, at a rising edge, cs_n=0, cas_n=0, ras_n=1 and we_n=1. Any other pin combination, including the read pattern with cs_n=1, starts no burst, and the strobe and data enables stay 0.
- R2: For a read sampled at edge k, the first beat is presented in cycle k+AL+CL, where AL=cfg_al and CL=cfg_cl. Cycle n is the interval after edge n. The valid range of cfg_cl is 2..7.
- R3: In cycle k+AL+CL-1 (preamble), dqs_oe_rise=dqs_oe_fall=1, dqs_rise=dqs_fall=0 and dq_oe=0.
- R4: A burst occupies BL/2 consecutive cycles, where BL=8 if cfg_bl8=1 and BL=4 otherwise. In each of these cycles dq_oe=1, dqs_oe_rise=dqs_oe_fall=1, dqs_rise=1 and dqs_fall=0.
- R5: In beat cycle j, dq_rise holds the word at column c(2j) and dq_fall holds the word at column c(2j+1). Here c(i) = (S - S mod BL) + ((S mod BL + i) mod BL) and S is the captured column, so the burst wraps inside a BL-aligned block.
- R6: In the cycle after the last beat (postamble), dqs_oe_rise=1, dqs_rise=0, dqs_oe_fall=0 and dq_oe=0. From the next cycle on, all enables are 0 until the next preamble.
- R7: A read sampled at edges k+1 through k+AL+CL+BL/2 (up to and including the postamble edge) is ignored. A read at edge k+AL+CL+BL/2+1 or later is accepted.
- R8: AL, CL and BL are captured at the accepting edge. Changing cfg_al, cfg_cl or cfg_bl8 during a burst has no effect on that burst.
- R9: While rst=1 at a rising edge, all strobe and data enables and the strobe levels are 0 from that edge on.
- R10: When ld_en=1 at a rising edge, ld_data is stored at column ld_addr and is returned by later bursts that cover that column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr | input | COL_W | Starting column sampled with a read |
| cfg_cl | input | LAT_W | CAS latency in cycles |
| cfg_al | input | LAT_W | Additive (posted) latency in cycles |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| ld_en | input | 1 | Storage load strobe |
| ld_addr | input | COL_W | Storage load column |
| ld_data | input | DATA_W | Storage load word |
| dq_rise | output | DATA_W | Data word for the rising half-cycle (even beat) |
| dq_fall | output | DATA_W | Data word for the falling half-cycle (odd beat) |
| dq_oe | output | 1 | Data output enable |
| dqs_rise | output | 1 | Strobe level in the rising half-cycle |
| dqs_fall | output | 1 | Strobe level in the falling half-cycle |
| dqs_oe_rise | output | 1 | Strobe enable in the rising half-cycle |
| dqs_oe_fall | output | 1 | Strobe enable in the falling half-cycle |

## Verification
Every output is registered. For a read sampled at edge k, the preamble is due in cycle k+AL+CL-1, beat pair j in cycle k+AL+CL+j, the postamble in cycle k+AL+CL+BL/2, and idle outputs one cycle later. The bench drives each command half a cycle before its sampling edge. It then checks each of the following cycles at the falling clock edge, indexing cycles by their distance m from the command edge and comparing against that schedule. Ignored commands and mid-burst configuration changes are placed on named cycles (m=1, the postamble edge, the first free edge), and their effect is judged on the strobe, enables and data words that follow.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  // Longest burst the sequencer supports; sizes the beat-pair index.
  localparam int MAX_BL = 8;
  localparam int PAIR_W = $clog2(MAX_BL / 2);

  // What the output drivers present in the coming cycle.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_BEAT = 2'd2,
    PH_POST = 2'd3
  } phase_e;
endpackage

// File: rtl/rdseq_cmd_decode.sv
module rdseq_cmd_decode #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [COL_W-1:0] addr,
  input  logic             busy,
  output logic             accept,
  output logic [COL_W-1:0] col_q
);
  logic is_read;

  // Column command with no row strobe and no write: a read.
  assign is_read = !cs_n && ras_n && !cas_n && we_n;
  assign accept  = is_read && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else if (accept) begin
      col_q <= addr;
    end
  end
endmodule

// File: rtl/rdseq_burst_timer.sv
module rdseq_burst_timer
  import rdseq_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic              cfg_bl8,
  output logic              busy,
  output logic              bl8_q,
  output phase_e            phase,
  output logic [PAIR_W-1:0] pair_idx
);
  // Holds AL+CL+MAX_BL/2 for the largest settings.
  localparam int CNT_W = LAT_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rl_q;
  logic [CNT_W-1:0] n_pairs;
  logic [CNT_W-1:0] beat_off;

  assign n_pairs  = bl8_q ? CNT_W'(MAX_BL / 2) : CNT_W'(MAX_BL / 4);
  assign beat_off = cnt - rl_q;

  // cnt equals the number of edges since the accepting edge, so the
  // phase decoded here is the one loaded into the output registers now.
  always_comb begin
    phase    = PH_IDLE;
    pair_idx = '0;
    if (busy) begin
      if (cnt == rl_q - CNT_W'(1)) begin
        phase = PH_PRE;
      end else if (cnt >= rl_q && cnt < rl_q + n_pairs) begin
        phase    = PH_BEAT;
        pair_idx = PAIR_W'(beat_off);
      end else if (cnt == rl_q + n_pairs) begin
        phase = PH_POST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      rl_q  <= '0;
      bl8_q <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(1);
      rl_q  <= CNT_W'(cfg_al) + CNT_W'(cfg_cl);
      bl8_q <= cfg_bl8;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
      if (phase == PH_POST) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdseq_col_gen.sv
module rdseq_col_gen
  import rdseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]      col_q,
  input  logic                  bl8,
  input  logic [PAIR_W-1:0]     pair_idx,
  output logic [1:0][COL_W-1:0] rd_col
);
  logic [COL_W-1:0] wrap_mask;

  assign wrap_mask = bl8 ? COL_W'(MAX_BL - 1) : COL_W'(MAX_BL / 2 - 1);

  // Half h of pair p is beat 2p+h; its column wraps inside the aligned block.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [COL_W-1:0] seq;
    assign seq       = col_q + COL_W'({pair_idx, 1'b0}) + COL_W'(h);
    assign rd_col[h] = (col_q & ~wrap_mask) | (seq & wrap_mask);
  end
endmodule

// File: rtl/rdseq_store.sv
module rdseq_store #(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   ld_en,
  input  logic [COL_W-1:0]       ld_addr,
  input  logic [DATA_W-1:0]      ld_data,
  input  logic [1:0][COL_W-1:0]  rd_col,
  output logic [1:0][DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end
  end

  // One registered read port per half-cycle word; the read register is
  // the output register.
  for (genvar h = 0; h < 2; h++) begin : g_port
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      q <= mem[rd_col[h]];
    end
    assign rd_data[h] = q;
  end
endmodule

// File: rtl/rdseq_drive.sv
module rdseq_drive
  import rdseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  output logic   dq_oe,
  output logic   dqs_rise,
  output logic   dqs_fall,
  output logic   dqs_oe_rise,
  output logic   dqs_oe_fall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe       <= 1'b0;
      dqs_rise    <= 1'b0;
      dqs_fall    <= 1'b0;
      dqs_oe_rise <= 1'b0;
      dqs_oe_fall <= 1'b0;
    end else begin
      unique case (phase)
        PH_PRE: begin
          dq_oe       <= 1'b0;
          dqs_rise    <= 1'b0;
          dqs_fall    <= 1'b0;
          dqs_oe_rise <= 1'b1;
          dqs_oe_fall <= 1'b1;
        end
        PH_BEAT: begin
          dq_oe       <= 1'b1;
          dqs_rise    <= 1'b1;
          dqs_fall    <= 1'b0;
          dqs_oe_rise <= 1'b1;
          dqs_oe_fall <= 1'b1;
        end
        PH_POST: begin
          dq_oe       <= 1'b0;
          dqs_rise    <= 1'b0;
          dqs_fall    <= 1'b0;
          dqs_oe_rise <= 1'b1;
          dqs_oe_fall <= 1'b0;
        end
        default: begin
          dq_oe       <= 1'b0;
          dqs_rise    <= 1'b0;
          dqs_fall    <= 1'b0;
          dqs_oe_rise <= 1'b0;
          dqs_oe_fall <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ddr_rd_sequencer.sv
module ddr_rd_sequencer
  import rdseq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  addr,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic              cfg_bl8,
  input  logic              ld_en,
  input  logic [COL_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] dq_rise,
  output logic [DATA_W-1:0] dq_fall,
  output logic              dq_oe,
  output logic              dqs_rise,
  output logic              dqs_fall,
  output logic              dqs_oe_rise,
  output logic              dqs_oe_fall
);
  logic                   busy;
  logic                   accept;
  logic                   bl8_q;
  logic [COL_W-1:0]       col_q;
  phase_e                 phase;
  logic [PAIR_W-1:0]      pair_idx;
  logic [1:0][COL_W-1:0]  rd_col;
  logic [1:0][DATA_W-1:0] rd_data;

  rdseq_cmd_decode #(.COL_W(COL_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .addr   (addr),
    .busy   (busy),
    .accept (accept),
    .col_q  (col_q)
  );

  rdseq_burst_timer #(.LAT_W(LAT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .cfg_cl   (cfg_cl),
    .cfg_al   (cfg_al),
    .cfg_bl8  (cfg_bl8),
    .busy     (busy),
    .bl8_q    (bl8_q),
    .phase    (phase),
    .pair_idx (pair_idx)
  );

  rdseq_col_gen #(.COL_W(COL_W)) u_cols (
    .col_q    (col_q),
    .bl8      (bl8_q),
    .pair_idx (pair_idx),
    .rd_col   (rd_col)
  );

  rdseq_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .rd_col  (rd_col),
    .rd_data (rd_data)
  );

  rdseq_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .dq_oe       (dq_oe),
    .dqs_rise    (dqs_rise),
    .dqs_fall    (dqs_fall),
    .dqs_oe_rise (dqs_oe_rise),
    .dqs_oe_fall (dqs_oe_fall)
  );

  assign dq_rise = rd_data[0];
  assign dq_fall = rd_data[1];
endmodule

// File: rtl/ddr_rd_sequencer_chk.sv
module ddr_rd_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic dq_oe,
  input logic dqs_rise,
  input logic dqs_fall,
  input logic dqs_oe_rise,
  input logic dqs_oe_fall
);
  logic [3:0] run_len;

  // Length of the current run of beat cycles.
  always_ff @(posedge clk) begin
    if (rst || !dq_oe) begin
      run_len <= '0;
    end else if (run_len != 4'hF) begin
      run_len <= run_len + 4'd1;
    end
  end

  assert_preamble_R3: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !$past(dq_oe)) |->
      $past(dqs_oe_rise && dqs_oe_fall && !dqs_rise && !dqs_fall));

  assert_beat_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (dqs_rise && !dqs_fall && dqs_oe_rise && dqs_oe_fall));

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (run_len < 4'd4));

  assert_postamble_R6: assert property (@(posedge clk) disable iff (rst)
    (!dq_oe && $past(dq_oe)) |-> (dqs_oe_rise && !dqs_oe_fall && !dqs_rise));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    $past(dqs_oe_rise && !dqs_oe_fall) |-> (!dqs_oe_rise && !dq_oe));

  assert_drive_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    dqs_oe_rise |-> $past(busy));
endmodule

bind ddr_rd_sequencer ddr_rd_sequencer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .dq_oe       (dq_oe),
  .dqs_rise    (dqs_rise),
  .dqs_fall    (dqs_fall),
  .dqs_oe_rise (dqs_oe_rise),
  .dqs_oe_fall (dqs_oe_fall)
);

// File: tb/ddr_rd_sequencer_tb.sv
`timescale 1ns/1ps
module ddr_rd_sequencer_tb;
  localparam int COL_W  = 10;
  localparam int DATA_W = 16;
  localparam int LAT_W  = 3;
  localparam int DEPTH  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [COL_W-1:0]  addr = '0;
  logic [LAT_W-1:0]  cfg_cl = 3'd3, cfg_al = 3'd0;
  logic              cfg_bl8 = 1'b0;
  logic              ld_en = 1'b0;
  logic [COL_W-1:0]  ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic [DATA_W-1:0] dq_rise, dq_fall;
  logic dq_oe, dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_rd_sequencer #(.COL_W(COL_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
    .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall)
  );

  function automatic logic [DATA_W-1:0] patt(int a);
    return DATA_W'(a * 37 + 16'h1234);
  endfunction

  function automatic int col_of(int start, bit bl8, int i);
    int bl = bl8 ? 8 : 4;
    return (start - (start % bl)) + ((start % bl + i) % bl);
  endfunction

  // {oe_rise, oe_fall, dqs_rise, dqs_fall, dq_oe}
  function automatic logic [4:0] ctl();
    return {dqs_oe_rise, dqs_oe_fall, dqs_rise, dqs_fall, dq_oe};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic nop();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic drive_read(int col);
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
    addr = COL_W'(col);
  endtask

  // Drive a pin pattern for one edge, return in the cycle after that edge.
  task automatic pulse_cmd(logic c, logic r, logic ca, logic w, int col);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = COL_W'(col);
    @(negedge clk);
    nop();
  endtask

  task automatic idle_window(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ctl() == 5'b0, req, "idle enables", 32'(ctl()), 32'h0);
    end
  endtask

  // Called in the cycle of the command edge k; checks cycles k+1..k+rl+np+1.
  // mode 1: intruding reads at m=1 and on the postamble edge, config changed.
  // mode 2: read for chain_col driven for the first free edge.
  task automatic burst_check(int start, int al, int cl, bit bl8, int mode, int chain_col);
    int rl = al + cl;
    int np = bl8 ? 4 : 2;
    for (int m = 1; m <= rl + np + 1; m++) begin
      @(negedge clk);
      nop();
      if (m < rl - 1) begin
        chk(ctl() == 5'b0, "R2", "wait enables", 32'(ctl()), 32'h0);
      end else if (m == rl - 1) begin
        chk(ctl() == 5'b11000, "R3", "preamble", 32'(ctl()), 32'h18);
      end else if (m < rl + np) begin
        int j = m - rl;
        chk(ctl() == 5'b11101, "R2 R4", "beat ctl", 32'(ctl()), 32'h1D);
        chk(dq_rise == patt(col_of(start, bl8, 2 * j)), "R5 R10", "rise word",
            32'(dq_rise), 32'(patt(col_of(start, bl8, 2 * j))));
        chk(dq_fall == patt(col_of(start, bl8, 2 * j + 1)), "R5 R10", "fall word",
            32'(dq_fall), 32'(patt(col_of(start, bl8, 2 * j + 1))));
      end else if (m == rl + np) begin
        chk(ctl() == 5'b10000, "R6", "postamble", 32'(ctl()), 32'h10);
      end else begin
        chk(ctl() == 5'b0, "R6", "released", 32'(ctl()), 32'h0);
      end
      if (mode == 1 && m == 1) begin
        drive_read((start + 3) % DEPTH);            // R7: busy, ignored
        cfg_al = 3'd5; cfg_cl = 3'd7; cfg_bl8 = !bl8; // R8: no effect
      end
      if (mode == 1 && m == rl + np - 1) drive_read((start + 5) % DEPTH); // R7 postamble edge
      if (mode == 2 && m == rl + np) drive_read(chain_col);               // R7 first free edge
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ctl() == 5'b0, "R9", "reset outputs", 32'(ctl()), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl() == 5'b0, "R9", "after reset", 32'(ctl()), 32'h0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = COL_W'(a); ld_data = patt(a);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic t_read(int start, int al, int cl, bit bl8);
    cfg_al = LAT_W'(al); cfg_cl = LAT_W'(cl); cfg_bl8 = bl8;
    pulse_cmd(1'b0, 1'b1, 1'b0, 1'b1, start);
    burst_check(start, al, cl, bl8, 0, 0);
  endtask

  task automatic t_nonread();
    cfg_al = 3'd0; cfg_cl = 3'd2; cfg_bl8 = 1'b0;
    pulse_cmd(1'b1, 1'b1, 1'b0, 1'b1, 4);   // deselected read pattern
    idle_window(8, "R1");
    pulse_cmd(1'b0, 1'b1, 1'b0, 1'b0, 4);   // write
    idle_window(8, "R1");
    pulse_cmd(1'b0, 1'b0, 1'b1, 1'b1, 4);   // row activate
    idle_window(8, "R1");
  endtask

  task automatic t_busy();
    cfg_al = 3'd3; cfg_cl = 3'd4; cfg_bl8 = 1'b1;
    pulse_cmd(1'b0, 1'b1, 1'b0, 1'b1, 12'h101);
    burst_check(12'h101, 3, 4, 1'b1, 1, 0);
    idle_window(16, "R7 R8");
  endtask

  task automatic t_chain();
    cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
    pulse_cmd(1'b0, 1'b1, 1'b0, 1'b1, 12'h022);
    burst_check(12'h022, 0, 3, 1'b0, 2, 12'h047);
    burst_check(12'h047, 0, 3, 1'b0, 0, 0);
  endtask

  initial begin
    nop();
    t_reset();
    t_preload();
    t_read(12'h010, 2, 3, 1'b0);   // R2 example latency 5, BL4
    t_read(13, 0, 2, 1'b1);        // R5 BL8 wrap inside block 8..15
    t_read(12'h3FE, 4, 5, 1'b0);   // R5 wrap in top block
    t_read(7, 5, 7, 1'b1);         // R2 longest latency
    t_nonread();
    t_busy();
    t_chain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule